// File: doc/BRIEF.md
# EDO DRAM Refresh and Initialization Sequencer

This block takes charge of keeping an EDO DRAM's contents alive. Out of reset it first idles through the power-up settling pause. It then runs a burst of initialization refresh cycles. After that it issues one column-strobe-before-row-strobe refresh per fixed interval, which spreads the full row sweep evenly over the retention period. Interval slots that cannot be served at once are queued in a small pending counter. When that counter is already full, a sticky error flag is raised.

The sequencer shares the DRAM pins with an access controller. It asks for the pins with a request line and starts a cycle only when the grant is present. While it owns the pins it drives the row strobe, both byte column strobes and write enable. A level-sensitive self-refresh request makes it park the device in self refresh. It only does this when no distributed refresh is outstanding, and it always holds the row strobe low for a parameterised time that sits safely beyond the entry threshold. Releasing the request brings the device out with an extended precharge. The distributed stream then restarts at once with a fresh refresh.

Top module: `refr_ctrl`

## Requirements
- R1: For PWR_CYC cycles after reset the row strobe and both column strobes stay high (inactive), bus_req stays low and init_done stays low.
- R2: After the power wait exactly INIT_CNT refresh cycles are run. init_done rises in the cycle after the last one finishes and never falls again until reset.
- R3: In each refresh cycle both column strobes (cas_n[1] upper byte, cas_n[0] lower byte) go low CSR_CYC cycles before the row strobe falls and stay low for CHR_CYC cycles after it. we_n is high in every cycle.
- R4: A distributed refresh holds the row strobe low for exactly RAS_CYC cycles. The row strobe is high for at least RP_CYC cycles before any fall.
- R5: Once init_done is high, one refresh falls due every INTERVAL cycles. Each due slot produces exactly one refresh cycle.
- R6: A cycle starts only from a cycle in which bus_gnt is high. bus_req is high whenever the row strobe is low, and stays high while refresh work is outstanding. With bus_gnt low no refresh starts.
- R7: Up to MAX_PEND due slots are queued. A slot that falls due while the queue is full sets ovf_err, which stays set until reset.
- R8: With sr_req high, init_done high and nothing pending, the sequencer runs a self-refresh entry. The column strobes fall, then the row strobe is held low with the column strobes low for SR_MIN_CYC+SR_MARGIN_CYC cycles, then sr_active rises and stays high while sr_req is high.
- R9: Dropping sr_req before the entry hold has elapsed does not shorten it. The row strobe stays low for the full hold plus one self-refresh cycle.
- R10: On leaving self refresh both strobes go high for RPS_CYC cycles. The interval timer restarts, and a distributed refresh is then started without waiting for an interval.
- R11: Pending distributed refreshes are served before a self-refresh entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_req | input | 1 | Level request to enter and remain in self refresh |
| bus_gnt | input | 1 | Pin ownership grant from the access controller |
| bus_req | output | 1 | Request for pin ownership |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes, [1] upper byte, [0] lower byte, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| init_done | output | 1 | Power wait and initialization refresh burst complete |
| sr_active | output | 1 | Device is parked in self refresh |
| ovf_err | output | 1 | Sticky: a due refresh slot was lost to a full queue |

## Verification
Assertions check on every cycle the properties that can be seen locally. They cover the column-before-row ordering and the column hold after the row fall, and the minimum row-low and precharge widths. They also cover bus ownership whenever the row strobe is low, the grant preceding every cycle start, strobe levels during self refresh, the full entry hold, queue bounds, and the stickiness of init_done and ovf_err. Properties that depend on counting and history are shown only by the bench scenarios and its cycle-by-cycle reference model. These are the exact number of init cycles, one refresh per interval, queue saturation while the grant is withheld, the priority of backlog over self refresh, and the immediate refresh after self-refresh exit.

// File: rtl/refr_pkg.sv
package refr_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_ACT,
        SQ_SELF,
        SQ_PCH
    } sq_state_e;

    typedef enum logic {
        OP_CBR,
        OP_SELF
    } op_kind_e;

    typedef struct packed {
        logic       row_n;
        logic [1:0] col_n;
        logic       wr_n;
    } strobe_t;

    function automatic int bits_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/refr_sched.sv
module refr_sched
    import refr_pkg::*;
#(
    parameter int PWR_CYC  = 40000,
    parameter int INIT_CNT = 8,
    parameter int INTERVAL = 3120,
    parameter int MAX_PEND = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cbr_done,
    input  logic sr_exit,
    input  logic sr_mode,
    output logic need_cbr,
    output logic init_done,
    output logic pend_zero,
    output logic ovf_err
);
    localparam int PW = bits_for(PWR_CYC);
    localparam int IW = bits_for(INIT_CNT);
    localparam int TW = bits_for(INTERVAL);
    localparam int QW = bits_for(MAX_PEND);

    logic [PW-1:0] pwr_cnt;
    logic          pwr_done;
    logic [IW-1:0] init_left;
    logic [TW-1:0] tmr;
    logic [QW-1:0] pending, pend_nxt;
    logic          ovf_q;
    logic          run, tick, dec;

    assign init_done = pwr_done && (init_left == '0);
    assign need_cbr  = pwr_done && ((init_left != '0) || (pending != '0));
    assign pend_zero = (pending == '0);
    assign ovf_err   = ovf_q;
    assign run  = init_done && !sr_mode;
    assign tick = run && (tmr == TW'(INTERVAL - 1));
    assign dec  = cbr_done && (init_left == '0);

    always_comb begin
        pend_nxt = pending;
        if (tick && !dec) begin
            if (pending != QW'(MAX_PEND)) pend_nxt = pending + 1'b1;
        end else if (!tick && dec && (pending != '0)) begin
            pend_nxt = pending - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_cnt   <= '0;
            pwr_done  <= 1'b0;
            init_left <= IW'(INIT_CNT);
            tmr       <= '0;
            pending   <= '0;
            ovf_q     <= 1'b0;
        end else begin
            if (!pwr_done) begin
                if (pwr_cnt == PW'(PWR_CYC - 1)) pwr_done <= 1'b1;
                else                             pwr_cnt  <= pwr_cnt + 1'b1;
            end
            if (cbr_done && (init_left != '0)) init_left <= init_left - 1'b1;
            if (sr_exit) begin
                tmr     <= '0;
                pending <= QW'(1);
            end else begin
                if (run) tmr <= tick ? '0 : tmr + 1'b1;
                pending <= pend_nxt;
                if (tick && !dec && (pending == QW'(MAX_PEND))) ovf_q <= 1'b1;
            end
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        pending <= QW'(MAX_PEND));
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    // R2
    init_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);
    // R1
    pwr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_done |-> (init_left == IW'(INIT_CNT)));

endmodule

// File: rtl/refr_seq.sv
module refr_seq
    import refr_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 2,
    parameter int RAS_CYC = 10,
    parameter int RP_CYC  = 6,
    parameter int SR_HOLD = 20200,
    parameter int RPS_CYC = 18
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    grant,
    input  logic    need_cbr,
    input  logic    sr_ok,
    input  logic    sr_req,
    output strobe_t strb,
    output logic    busy,
    output logic    sr_mode,
    output logic    sr_active,
    output logic    cbr_done,
    output logic    sr_exit
);
    localparam int LMAX = max3(max3(CSR_CYC, RAS_CYC, RP_CYC), SR_HOLD, RPS_CYC);
    localparam int CW   = bits_for(LMAX);
    localparam int RW   = bits_for(LMAX + 1);

    sq_state_e     state;
    op_kind_e      kind;
    logic [CW-1:0] cnt, len_m1;
    logic          last;
    logic [RW-1:0] low_run, high_run;
    logic          row_n;
    logic [1:0]    col_n;

    always_comb begin
        case (state)
            SQ_PRE:  len_m1 = CW'(CSR_CYC - 1);
            SQ_ACT:  len_m1 = (kind == OP_SELF) ? CW'(SR_HOLD - 1) : CW'(RAS_CYC - 1);
            SQ_PCH:  len_m1 = (kind == OP_SELF) ? CW'(RPS_CYC - 1) : CW'(RP_CYC - 1);
            default: len_m1 = '0;
        endcase
    end
    assign last = (cnt == len_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            kind  <= OP_CBR;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (grant && (need_cbr || sr_ok)) begin
                    state <= SQ_PRE;
                    cnt   <= '0;
                    kind  <= need_cbr ? OP_CBR : OP_SELF;
                end
                SQ_PRE: if (last) begin
                    state <= SQ_ACT;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                SQ_ACT: if (last) begin
                    state <= (kind == OP_SELF) ? SQ_SELF : SQ_PCH;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                SQ_SELF: if (!sr_req) begin
                    state <= SQ_PCH;
                    cnt   <= '0;
                end
                SQ_PCH: if (last) begin
                    state <= SQ_IDLE;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign row_n = !((state == SQ_ACT) || (state == SQ_SELF));
    assign col_n = ((state == SQ_PRE) || (state == SQ_SELF) ||
                    ((state == SQ_ACT) && ((kind == OP_SELF) || (cnt < CW'(CHR_CYC)))))
                   ? 2'b00 : 2'b11;
    assign strb      = '{row_n: row_n, col_n: col_n, wr_n: 1'b1};
    assign busy      = (state != SQ_IDLE);
    assign sr_mode   = busy && (kind == OP_SELF);
    assign sr_active = (state == SQ_SELF);
    assign cbr_done  = (state == SQ_PCH) && last && (kind == OP_CBR);
    assign sr_exit   = (state == SQ_SELF) && !sr_req;

    // run-length counters used only by the checks below
    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= '1;
        end else if (!row_n) begin
            high_run <= '0;
            if (low_run != '1) low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
            if (high_run != '1) high_run <= high_run + 1'b1;
        end
    end

    // R3
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(row_n) |-> (col_n == 2'b00) && ($past(col_n) == 2'b00));
    // R3
    cas_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(row_n) |=> (col_n == 2'b00));
    // R4
    ras_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(row_n) |-> (low_run >= RW'(RAS_CYC)));
    // R4
    precharge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(row_n) |-> (high_run >= RW'(RP_CYC)));
    // R8
    self_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        sr_active |-> (!row_n && (col_n == 2'b00)));
    // R9
    self_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_active) |-> (low_run >= RW'(SR_HOLD)));

endmodule

// File: rtl/refr_ctrl.sv
module refr_ctrl
    import refr_pkg::*;
#(
    parameter int PWR_CYC       = 40000,
    parameter int INIT_CNT      = 8,
    parameter int INTERVAL      = 3120,
    parameter int MAX_PEND      = 4,
    parameter int CSR_CYC       = 1,
    parameter int CHR_CYC       = 2,
    parameter int RAS_CYC       = 10,
    parameter int RP_CYC        = 6,
    parameter int SR_MIN_CYC    = 20000,
    parameter int SR_MARGIN_CYC = 200,
    parameter int RPS_CYC       = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sr_req,
    input  logic       bus_gnt,
    output logic       bus_req,
    output logic       ras_n,
    output logic [1:0] cas_n,
    output logic       we_n,
    output logic       init_done,
    output logic       sr_active,
    output logic       ovf_err
);
    localparam int SR_HOLD = SR_MIN_CYC + SR_MARGIN_CYC;

    logic    need_cbr, pend_zero, sr_ok, busy, sr_mode, cbr_done, sr_exit;
    strobe_t strb;

    assign sr_ok = init_done && pend_zero && sr_req;

    refr_sched #(
        .PWR_CYC(PWR_CYC), .INIT_CNT(INIT_CNT),
        .INTERVAL(INTERVAL), .MAX_PEND(MAX_PEND)
    ) u_sched (
        .clk(clk), .rst(rst), .cbr_done(cbr_done), .sr_exit(sr_exit),
        .sr_mode(sr_mode), .need_cbr(need_cbr), .init_done(init_done),
        .pend_zero(pend_zero), .ovf_err(ovf_err)
    );

    refr_seq #(
        .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC),
        .RP_CYC(RP_CYC), .SR_HOLD(SR_HOLD), .RPS_CYC(RPS_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .grant(bus_gnt), .need_cbr(need_cbr),
        .sr_ok(sr_ok), .sr_req(sr_req), .strb(strb), .busy(busy),
        .sr_mode(sr_mode), .sr_active(sr_active), .cbr_done(cbr_done),
        .sr_exit(sr_exit)
    );

    assign bus_req = busy || need_cbr || sr_ok;
    assign ras_n   = strb.row_n;
    assign cas_n   = strb.col_n;
    assign we_n    = strb.wr_n;

    // R6
    own_chk: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> bus_req);
    // R6
    start_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n[0]) && ras_n) |-> $past(bus_gnt));

endmodule

// File: tb/sim_refr_ctrl.sv
`timescale 1ns/1ps
module sim_refr_ctrl;
    localparam int P_PWR = 20, P_INIT = 8, P_INT = 60, P_MAXP = 3;
    localparam int P_CSR = 1, P_CHR = 2, P_RAS = 10, P_RP = 6;
    localparam int P_SRMIN = 100, P_SRM = 10, P_RPS = 18;
    localparam int HOLD = P_SRMIN + P_SRM;
    localparam int CBR_LEN = P_CSR + P_RAS + P_RP;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, sr_req = 1'b0, bus_gnt = 1'b1;
    logic bus_req, ras_n, we_n, init_done, sr_active, ovf_err;
    logic [1:0] cas_n;

    refr_ctrl #(
        .PWR_CYC(P_PWR), .INIT_CNT(P_INIT), .INTERVAL(P_INT), .MAX_PEND(P_MAXP),
        .CSR_CYC(P_CSR), .CHR_CYC(P_CHR), .RAS_CYC(P_RAS), .RP_CYC(P_RP),
        .SR_MIN_CYC(P_SRMIN), .SR_MARGIN_CYC(P_SRM), .RPS_CYC(P_RPS)
    ) u0 (
        .clk(clk), .rst(rst), .sr_req(sr_req), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .init_done(init_done), .sr_active(sr_active), .ovf_err(ovf_err)
    );

    int n_chk = 0, n_fail = 0;
    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_inpwr, m_pwr, m_init, m_pend, m_tmr, m_ovf, m_op, m_pos;
    bit  started = 0;
    bit  b_done, b_need, b_srok, b_run, b_tick, b_fin, b_leave, b_dec;

    always @(posedge clk) begin
        if (rst) begin
            m_inpwr = 1; m_pwr = 0; m_init = P_INIT; m_pend = 0;
            m_tmr = 0; m_ovf = 0; m_op = 0; m_pos = 0; started = 1;
        end else if (started) begin
            b_done = (m_inpwr == 0) && (m_init == 0);
            b_need = (m_inpwr == 0) && (m_init != 0 || m_pend != 0);
            b_srok = b_done && (m_pend == 0) && sr_req;
            b_run  = b_done && (m_op != 2);
            b_tick = b_run && (m_tmr == P_INT - 1);
            b_fin = 0; b_leave = 0;
            if (m_inpwr != 0) begin
                m_pwr++;
                if (m_pwr == P_PWR) m_inpwr = 0;
            end else if (m_op == 0) begin
                if (bus_gnt && (b_need || b_srok)) begin m_op = b_need ? 1 : 2; m_pos = 0; end
            end else if (m_op == 1) begin
                m_pos++;
                if (m_pos == CBR_LEN) begin m_op = 0; b_fin = 1; end
            end else begin
                if (m_pos == P_CSR + HOLD) begin
                    if (!sr_req) begin m_pos++; b_leave = 1; end
                end else begin
                    m_pos++;
                    if (m_pos == P_CSR + HOLD + P_RPS + 1) m_op = 0;
                end
            end
            b_dec = b_fin && (m_init == 0);
            if (b_fin && m_init > 0) m_init--;
            if (b_leave) begin m_tmr = 0; m_pend = 1; end
            else begin
                if (b_run) m_tmr = b_tick ? 0 : m_tmr + 1;
                if (b_tick && !b_dec) begin
                    if (m_pend == P_MAXP) m_ovf = 1; else m_pend++;
                end else if (!b_tick && b_dec && m_pend > 0) m_pend--;
            end
        end
    end

    int e_ras, e_cas, e_req, e_done, e_sra;
    always @(negedge clk) begin
        if (started) begin
            e_ras = 1; e_cas = 3;
            if (m_op == 1) begin
                if (m_pos < P_CSR) e_cas = 0;
                else if (m_pos < P_CSR + P_RAS) begin
                    e_ras = 0; e_cas = (m_pos - P_CSR < P_CHR) ? 0 : 3;
                end
            end else if (m_op == 2) begin
                if (m_pos < P_CSR) e_cas = 0;
                else if (m_pos <= P_CSR + HOLD) begin e_ras = 0; e_cas = 0; end
            end
            e_done = (m_inpwr == 0 && m_init == 0) ? 1 : 0;
            e_sra  = (m_op == 2 && m_pos == P_CSR + HOLD) ? 1 : 0;
            e_req  = (m_op != 0 || (m_inpwr == 0 && (m_init != 0 || m_pend != 0)) ||
                      (e_done == 1 && m_pend == 0 && sr_req)) ? 1 : 0;
            check("R4", "ras_n", int'(ras_n), e_ras);
            check("R3", "cas_n", int'(cas_n), e_cas);
            check("R3", "we_n", int'(we_n), 1);
            check("R6", "bus_req", int'(bus_req), e_req);
            check("R2", "init_done", int'(init_done), e_done);
            check("R8", "sr_active", int'(sr_active), e_sra);
            check("R7", "ovf_err", int'(ovf_err), m_ovf);
        end
    end

    // ---------------- pulse monitor ----------------
    int nfall = 0, lowlen = 0, highlen = 0, last_low = 0, last_high = 0;
    logic prev_ras = 1'b1;
    always @(negedge clk) begin
        if (started && !rst) begin
            if (!ras_n) begin
                if (prev_ras) begin nfall++; last_high = highlen; lowlen = 0; end
                lowlen++;
            end else begin
                if (!prev_ras) begin last_low = lowlen; highlen = 0; end
                highlen++;
            end
            prev_ras = ras_n;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask
    task automatic settle();
        @(negedge clk); #1;
    endtask
    task automatic wait_ras_rise();
        @(posedge ras_n); settle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            finish_run();
        end
    end

    int f0;
    initial begin
        cyc(4);
        rst = 1'b0;
        settle();
        // R1: power wait quiet
        check("R1", "ras_n in pwr wait", int'(ras_n), 1);
        check("R1", "cas_n in pwr wait", int'(cas_n), 3);
        check("R1", "bus_req in pwr wait", int'(bus_req), 0);
        cyc(P_PWR - 4);
        settle();
        check("R1", "bus_req late pwr wait", int'(bus_req), 0);
        check("R1", "init_done in pwr wait", int'(init_done), 0);

        // R2: init burst
        @(posedge init_done); settle();
        check("R2", "init refresh count", nfall, P_INIT);
        check("R4", "init ras low width", last_low, P_RAS);

        // R5: one refresh per interval
        f0 = nfall;
        cyc(3 * P_INT + 20);
        check("R5", "refreshes in three intervals", nfall - f0, 3);
        check("R4", "distributed ras low width", last_low, P_RAS);

        // R6 / R7: withhold grant
        wait_ras_rise();
        @(posedge clk); #1 bus_gnt = 1'b0;
        f0 = nfall;
        cyc(5 * P_INT);
        settle();
        check("R6", "no refresh without grant", nfall - f0, 0);
        check("R6", "bus_req while backlog", int'(bus_req), 1);
        check("R7", "overflow flagged", int'(ovf_err), 1);
        @(posedge clk); #1 bus_gnt = 1'b1;
        f0 = nfall;
        cyc(3 * CBR_LEN + 6);
        check("R7", "queued refreshes drained", (nfall - f0 >= P_MAXP) ? 1 : 0, 1);
        check("R7", "overflow sticky", int'(ovf_err), 1);

        // R11: backlog before self refresh
        wait_ras_rise();
        @(posedge clk); #1 bus_gnt = 1'b0;
        cyc(P_INT + 5);
        sr_req = 1'b1;
        cyc(3);
        bus_gnt = 1'b1;
        wait_ras_rise();
        check("R11", "first pulse is a distributed refresh", last_low, P_RAS);

        // R8: long self refresh
        @(posedge sr_active); settle();
        check("R8", "ras low in self refresh", int'(ras_n), 0);
        cyc(50);
        settle();
        check("R8", "still in self refresh", int'(sr_active), 1);
        sr_req = 1'b0;
        wait_ras_rise();
        check("R8", "self refresh hold length", (last_low >= HOLD + 1) ? 1 : 0, 1);

        // R10: exit precharge then immediate refresh
        @(negedge ras_n); settle();
        check("R10", "exit precharge gap", last_high, P_RPS + 1 + P_CSR);
        wait_ras_rise();
        check("R10", "refresh after exit", last_low, P_RAS);

        // R9: short self refresh request
        sr_req = 1'b1;
        @(negedge ras_n);
        cyc(5);
        sr_req = 1'b0;
        wait_ras_rise();
        check("R9", "entry hold not shortened", last_low, HOLD + 1);
        cyc(2 * P_INT);
        finish_run();
    end
endmodule